// File: doc/BRIEF.md
# SPI Serial EEPROM Target Engine

This block is a synthesizable behavioural model of a byte-wide serial EEPROM that answers on an SPI bus. A fast system clock samples the four bus inputs (clock, active-low select, data in, active-low pause). The block drives one data-out line together with an output-enable, so the chip's pad ring supplies the tri-state buffer. Each selection begins with an 8-bit command. Array reads and writes then take a 16-bit address, MSB first. Writes gather up to one page of bytes in a page buffer. They reach the register-file array only when the select line rises, and that starts a self-timed commit period during which the device reports busy.

Protection decisions come from a separate permission unit. The engine raises a one-cycle request when a write or status update ends. The unit grants it from the write-enable latch, the protection level and the target page. The bus clock must run at no more than a quarter of the system clock, because every input passes through a synchroniser before its edges are found.

Top module: `spiee_top`

## Requirements
- R1: The command byte is decoded as 0x06 set write latch, 0x04 clear write latch, 0x05 status read, 0x01 status write, 0x03 array read and 0x02 page load. Any other value is ignored, and the output-enable stays low until the select line rises.
- R2: Data in is taken on rising bus-clock edges and data out changes on falling edges, MSB first. This works both with an idle-low clock and with an idle-high clock. The output-enable is low whenever the select line is high.
- R3: The 16-bit address that follows a read or page-load command uses only its low ADDR_W bits, and the upper bits have no effect.
- R4: An array read streams bytes for as long as the clock runs. The address increments after every byte and wraps from the top address to 0.
- R5: During a page load, each data byte steps only the low PAGE_W address bits and the page bits stay fixed. Bytes past the end of the page wrap to the first byte of the same page and overwrite earlier bytes.
- R6: A page load commits only at the rising select edge, and only when the write latch is set, at least one whole byte was loaded, the select rises on a byte boundary and the page is not protected. A trailing partial byte discards the whole load.
- R7: Page bytes that were not loaded in a commit keep their earlier array contents.
- R8: The status byte is {4'b0000, level[1:0], latch, busy}. Busy (bit 0) reads 1 for COMMIT_CYC system cycles after a commit starts. A granted commit clears the latch (bit 1).
- R9: While busy, every command except the status read is ignored.
- R10: The set-latch and clear-latch commands act only when the select rises after exactly 8 clock bits.
- R11: A status write of exactly one data byte, with the latch set, loads the protection level from bits 3:2 of that byte. Level 0 protects nothing, 1 the top quarter, 2 the top half and 3 the whole array. A page load aimed at a protected page is discarded and leaves the latch set.
- R12: A falling pause input while the bus clock is low freezes the session: the output-enable drops and bus-clock and data-in activity is ignored. A rising pause input while the clock is low resumes the session at the same bit.
- R13: The status read streams the live status byte again and again while the clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Bus clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Active-low pause |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output-enable for the data-out pad |

## Verification
Every bus input reaches the logic after two synchroniser flops and one edge register. A data-out bit therefore settles about four system cycles after the falling bus-clock edge that calls for it. The bench samples each bit half a bus period later, just before the next rising edge. A commit and the busy flag begin in the system cycle after the select rise is detected, so a status read issued right after a page load must see busy, and the busy time is bracketed by the length of the polling reads. A per-cycle monitor requires the output-enable to be low once the select line has been high for more than six cycles.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
   localparam logic [7:0] OP_SETWL = 8'h06;
   localparam logic [7:0] OP_CLRWL = 8'h04;
   localparam logic [7:0] OP_STRD  = 8'h05;
   localparam logic [7:0] OP_STWR  = 8'h01;
   localparam logic [7:0] OP_ARD   = 8'h03;
   localparam logic [7:0] OP_PLD   = 8'h02;

   typedef enum logic [2:0] {
      S_IDLE, S_OP, S_ADDR, S_RDATA, S_WDATA, S_SRW, S_SOUT, S_DONE
   } phase_t;
endpackage

// File: rtl/spiee_sync.sv
module spiee_sync #(
   parameter int W = 4,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] lvl
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spiee_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], raw[b]};
      end
      assign lvl[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/spiee_guard.sv
module spiee_guard #(
   parameter int PG_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic is_stat,
   input  logic [PG_W-1:0] page,
   input  logic wel,
   input  logic [1:0] lvl,
   output logic gnt
);
   if (PG_W < 2) begin : g_bad_pg
      $error("spiee_guard: PG_W must be at least 2");
   end

   logic locked;
   always_comb begin
      case (lvl)
         2'd1:    locked = &page[PG_W-1 -: 2];
         2'd2:    locked = page[PG_W-1];
         2'd3:    locked = 1'b1;
         default: locked = 1'b0;
      endcase
   end
   assign gnt = req && wel && (is_stat || !locked);

   AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !is_stat && lvl == 2'd3) |-> !gnt); // R11
   AST_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      gnt |-> (wel && req)); // R6
endmodule

// File: rtl/spiee_timer.sv
module spiee_timer #(
   parameter int CYC = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYC + 1);
   if (CYC < 2) begin : g_bad_cyc
      $error("spiee_timer: CYC must be at least 2");
   end

   logic [CW-1:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == CW'(CYC - 1)) busy <= 1'b0;
         else                     cnt  <= cnt + 1'b1;
      end
   end

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R9
endmodule

// File: rtl/spiee_top.sv
module spiee_top
   import spiee_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 5,
   parameter int COMMIT_CYC = 1000000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_si,
   input  logic spi_hold_n,
   output logic spi_so,
   output logic spi_so_oe
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int PAGE_B = 1 << PAGE_W;
   localparam int PG_W   = ADDR_W - PAGE_W;

   if (PAGE_W < 1 || ADDR_W < PAGE_W + 2 || ADDR_W > 16) begin : g_bad_geom
      $error("spiee_top: address geometry out of range");
   end

   // synchronised levels: [3]=cs_n [2]=sck [1]=hold_n [0]=si
   logic [3:0] lvl;
   logic [2:0] prv;
   spiee_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .raw({spi_cs_n, spi_sck, spi_hold_n, spi_si}), .lvl(lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= 3'b101;
      else        prv <= lvl[3:1];
   end

   logic cs_l, sck_l, si_l;
   logic cs_f, cs_r, sck_r, sck_f, hold_f, hold_r;
   assign cs_l   = lvl[3];
   assign sck_l  = lvl[2];
   assign si_l   = lvl[0];
   assign cs_f   = !lvl[3] &&  prv[2];
   assign cs_r   =  lvl[3] && !prv[2];
   assign sck_r  =  lvl[2] && !prv[1];
   assign sck_f  = !lvl[2] &&  prv[1];
   assign hold_f = !lvl[1] &&  prv[0];
   assign hold_r =  lvl[1] && !prv[0];

   phase_t st;
   logic [4:0] cnt;
   logic [7:0] sr, opc;
   logic [ADDR_W-2:0] ad;
   logic [ADDR_W-1:0] addr;
   logic [PAGE_B-1:0] vmask;
   logic [7:0] pbuf [PAGE_B];
   logic [7:0] mem  [DEPTH];
   logic [1:0] lvl_q, sr2;
   logic have, out_on, paused, so_q, wel, busy;
   logic [2:0] obit;

   logic go_r, go_f;
   assign go_r = sck_r && !paused && !cs_l;
   assign go_f = sck_f && !paused && !cs_l;

   logic [7:0] nb, stat, outbyte;
   assign nb      = {sr[6:0], si_l};
   assign stat    = {4'b0000, lvl_q, wel, busy};
   assign outbyte = (st == S_SOUT) ? stat : mem[addr];

   logic wr_cand, sr_cand, gnt, wr_go, sr_go;
   assign wr_cand = cs_r && st == S_WDATA && have && cnt[2:0] == 3'd0;
   assign sr_cand = cs_r && st == S_SRW && cnt == 5'd8;
   assign wr_go   = wr_cand && gnt;
   assign sr_go   = sr_cand && gnt;

   spiee_guard #(.PG_W(PG_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .req(wr_cand || sr_cand), .is_stat(sr_cand),
      .page(addr[ADDR_W-1:PAGE_W]), .wel(wel), .lvl(lvl_q), .gnt(gnt));

   spiee_timer #(.CYC(COMMIT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(wr_go || sr_go), .busy(busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) paused <= 1'b0;
      else if (cs_l) paused <= 1'b0;
      else if (hold_f && !sck_l) paused <= 1'b1;
      else if (hold_r && !sck_l) paused <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; cnt <= '0; sr <= '0; opc <= '0; ad <= '0; addr <= '0;
         vmask <= '0; have <= 1'b0; out_on <= 1'b0; so_q <= 1'b0; obit <= '0;
         wel <= 1'b0; lvl_q <= '0; sr2 <= '0;
      end else if (cs_f) begin
         st <= S_OP; cnt <= '0; out_on <= 1'b0; obit <= '0;
      end else if (cs_r) begin
         st <= S_IDLE; out_on <= 1'b0;
         if (st == S_DONE && opc == OP_SETWL) wel <= 1'b1;
         if (st == S_DONE && opc == OP_CLRWL) wel <= 1'b0;
         if (wr_go) wel <= 1'b0;
         if (sr_go) begin wel <= 1'b0; lvl_q <= sr2; end
      end else if (go_r) begin
         sr <= nb;
         case (st)
            S_OP: begin
               cnt <= cnt + 1'b1;
               if (cnt == 5'd7) begin
                  opc <= nb;
                  cnt <= '0;
                  if (busy && nb != OP_STRD) st <= S_IDLE;
                  else case (nb)
                     OP_ARD, OP_PLD:   st <= S_ADDR;
                     OP_STRD:          begin st <= S_SOUT; out_on <= 1'b1; obit <= '0; end
                     OP_STWR:          st <= S_SRW;
                     OP_SETWL, OP_CLRWL: st <= S_DONE;
                     default:          st <= S_IDLE;
                  endcase
               end
            end
            S_ADDR: begin
               ad  <= {ad[ADDR_W-3:0], si_l};
               cnt <= cnt + 1'b1;
               if (cnt == 5'd15) begin
                  addr <= {ad, si_l};
                  cnt  <= '0;
                  if (opc == OP_ARD) begin st <= S_RDATA; out_on <= 1'b1; obit <= '0; end
                  else begin st <= S_WDATA; vmask <= '0; have <= 1'b0; end
               end
            end
            S_WDATA: begin
               cnt <= cnt + 1'b1;
               if (cnt[2:0] == 3'd7) begin
                  pbuf[addr[PAGE_W-1:0]]  <= nb;
                  vmask[addr[PAGE_W-1:0]] <= 1'b1;
                  addr[PAGE_W-1:0]        <= addr[PAGE_W-1:0] + 1'b1;
                  have                    <= 1'b1;
               end
            end
            S_SRW: begin
               cnt <= cnt + 1'b1;
               if (cnt == 5'd7) sr2 <= nb[3:2];
               if (cnt == 5'd8) st <= S_IDLE;
            end
            S_DONE: st <= S_IDLE;
            default: ;
         endcase
      end else if (go_f && out_on) begin
         so_q <= outbyte[3'd7 - obit];
         obit <= obit + 1'b1;
         if (obit == 3'd7 && st == S_RDATA) addr <= addr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_go) begin
         for (int i = 0; i < PAGE_B; i++) begin
            if (vmask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
         end
      end
   end

   assign spi_so    = so_q;
   assign spi_so_oe = out_on && !paused;

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_l && $past(cs_l)) |-> !spi_so_oe); // R2
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && $past(paused)) |-> ($stable(cnt) && $stable(obit))); // R12
   AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WDATA && $past(st == S_WDATA))
         |-> $stable(addr[ADDR_W-1:PAGE_W])); // R5
   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_go && sr_go)); // R6
endmodule

// File: tb/spiee_top_bench.sv
module spiee_top_bench;
   localparam int COMMIT = 1500;
   localparam int H = 8;
   localparam int AW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, spi_hold_n = 1'b1;
   logic spi_so, spi_so_oe;

   always #2 clk = ~clk;

   spiee_top #(.ADDR_W(AW), .PAGE_W(5), .COMMIT_CYC(COMMIT)) u_spiee_top (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_si(spi_si), .spi_hold_n(spi_hold_n), .spi_so(spi_so),
      .spi_so_oe(spi_so_oe));

   int checks = 0, errors = 0, cyc = 0, csq = 0;
   bit mode3 = 1'b0, done = 1'b0;
   logic [7:0] mm [1 << AW];
   bit m_wel = 1'b0;
   logic [1:0] m_lvl = 2'd0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      csq = spi_cs_n ? csq + 1 : 0;
      if (rst_n && csq > 6 && spi_so_oe) begin
         errors++;
         $display("FAIL R2 actual=%0h expected=%0h", 1, 0);
      end
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", cyc, 190000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] pat(input int s, input int k);
      return 8'(s * 13 + k * 29 + 5);
   endfunction

   function automatic bit hit(input logic [AW-1:0] a);
      case (m_lvl)
         2'd1: return a[AW-1] && a[AW-2];
         2'd2: return a[AW-1];
         2'd3: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic sel();
      spi_sck = mode3;
      tick(2);
      spi_cs_n = 1'b0;
      tick(H);
   endtask

   task automatic desel();
      if (!mode3) begin spi_sck = 1'b0; tick(H); end
      spi_cs_n = 1'b1;
      tick(2 * H);
   endtask

   task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx, output bit oe);
      rx = '0; oe = 1'b0;
      for (int i = 7; i > 7 - n; i--) begin
         spi_sck = 1'b0; spi_si = tx[i];
         tick(H);
         rx[i] = spi_so; oe |= spi_so_oe;
         spi_sck = 1'b1;
         tick(H);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe);
      xbits(tx, 8, rx, oe);
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] r; bit o;
      sel(); xfer(op, r, o); desel();
   endtask

   task automatic rdsr(output logic [7:0] s);
      bit o;
      sel(); xfer(8'h05, s, o); xfer(8'h00, s, o); desel();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] r; bit o;
      sel(); xfer(8'h01, r, o); xfer(v, r, o); desel();
      if (m_wel) begin m_lvl = v[3:2]; m_wel = 1'b0; end
   endtask

   task automatic wr(input logic [15:0] a, input int n, input int s);
      logic [7:0] r; bit o;
      logic [AW-1:0] a2;
      sel(); xfer(8'h02, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
      for (int k = 0; k < n; k++) xfer(pat(s, k), r, o);
      desel();
      a2 = a[AW-1:0];
      if (m_wel && n > 0 && !hit(a2)) begin
         for (int k = 0; k < n; k++) mm[{a2[AW-1:5], 5'(a2[4:0] + k)}] = pat(s, k);
         m_wel = 1'b0;
      end
   endtask

   task automatic rd(input logic [15:0] a, input int n, input string req);
      logic [7:0] r; bit o;
      logic [AW-1:0] ix;
      sel(); xfer(8'h03, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, r, o);
         ix = AW'(a[AW-1:0] + k);
         check(o && r == mm[ix], req, {o, r}, {1'b1, mm[ix]});
      end
      desel();
   endtask

   task automatic idle();
      tick(COMMIT + 50);
   endtask

   task automatic stat_chk(input string req, input logic [7:0] exp);
      logic [7:0] s;
      rdsr(s);
      check(s == exp, req, s, exp);
   endtask

   initial begin
      logic [7:0] s, r, r2;
      bit o;
      int t0;
      tick(10);
      rst_n = 1'b1;
      tick(10);
      check(spi_so_oe == 1'b0, "R2 reset", spi_so_oe, 0);
      stat_chk("R13 reset status", 8'h00);

      // R10 latch set / clear, exact 8 bits
      cmd(8'h06); stat_chk("R10 set", 8'h02);
      cmd(8'h04); stat_chk("R10 clear", 8'h00);
      sel(); xfer(8'h06, r, o); xfer(8'h00, r, o); desel();
      stat_chk("R10 extra bits", 8'h00);

      // first page load, busy and R9 ignore while busy
      cmd(8'h06); m_wel = 1'b1;
      wr(16'h0040, 32, 1);
      t0 = cyc;
      stat_chk("R8 busy after commit", 8'h01);
      cmd(8'h06);
      stat_chk("R9 command ignored while busy", 8'h01);
      s = 8'h01;
      for (int p = 0; p < 20 && s[0]; p++) rdsr(s);
      check(s == 8'h00, "R9 latch stays clear", s, 0);
      check((cyc - t0) >= COMMIT - 300 && (cyc - t0) <= COMMIT + 700,
            "R8 busy length", cyc - t0, COMMIT);

      cmd(8'h06); m_wel = 1'b1; wr(16'h0000, 32, 2); idle();
      cmd(8'h06); m_wel = 1'b1; wr(16'h03E0, 32, 3); idle();
      cmd(8'h06); m_wel = 1'b1; wr(16'h0100, 32, 4); idle();
      cmd(8'h06); m_wel = 1'b1; wr(16'h0300, 32, 5); idle();
      cmd(8'h06); m_wel = 1'b1; wr(16'h02E0, 32, 6); idle();
      rd(16'h0040, 32, "R4 stream read");

      // R6 no latch: discarded
      wr(16'h0100, 3, 7); tick(100);
      stat_chk("R6 no latch no busy", 8'h00);
      rd(16'h0100, 4, "R6 no latch unchanged");

      // R3 upper address bits ignored, R7 unloaded bytes kept
      cmd(8'h06); m_wel = 1'b1; wr(16'hFC45, 3, 8); idle();
      rd(16'hA040, 32, "R3 R7 partial page");

      // R5 wrap inside page and overwrite
      cmd(8'h06); m_wel = 1'b1; wr(16'h005E, 4, 9); idle();
      rd(16'h0040, 32, "R5 page wrap");
      cmd(8'h06); m_wel = 1'b1; wr(16'h0000, 34, 10); idle();
      rd(16'h0000, 32, "R5 overwrite");

      // R6 partial trailing byte discards everything
      cmd(8'h06);
      sel(); xfer(8'h02, r, o); xfer(8'h00, r, o); xfer(8'h40, r, o);
      xfer(8'hAA, r, o); xbits(8'h55, 4, r, o); desel();
      tick(100);
      stat_chk("R6 partial byte no commit", 8'h02);
      rd(16'h0040, 2, "R6 partial byte data");
      cmd(8'h04);

      // R4 wrap at top of array
      rd(16'h03FE, 4, "R4 top wrap");

      // R1 unknown command
      sel(); xfer(8'hA5, r, o);
      begin
         bit any = 1'b0;
         for (int k = 0; k < 3; k++) begin xfer(8'h00, r, o); any |= o; end
         check(!any, "R1 unknown command quiet", any, 0);
      end
      desel();
      stat_chk("R1 no side effect", 8'h00);

      // R11 protection levels
      cmd(8'h06); m_wel = 1'b1; wrsr(8'h04); idle();
      stat_chk("R11 level 1 stored", 8'h04);
      cmd(8'h06); m_wel = 1'b1; wr(16'h0310, 2, 11); tick(100);
      stat_chk("R11 denied keeps latch", 8'h06);
      rd(16'h0310, 2, "R11 top quarter locked");
      wr(16'h02E0, 2, 12); idle();
      rd(16'h02E0, 2, "R11 lower allowed");
      cmd(8'h06); m_wel = 1'b1; wrsr(8'h0C); idle();
      cmd(8'h06); m_wel = 1'b1; wr(16'h0000, 1, 13); tick(100);
      rd(16'h0000, 2, "R11 full lock");
      cmd(8'h06); m_wel = 1'b1; wrsr(8'h00); idle();
      stat_chk("R11 level cleared", 8'h00);

      // R2 idle-high clock
      mode3 = 1'b1;
      rd(16'h03E0, 4, "R2 idle-high clock read");
      mode3 = 1'b0;
      spi_sck = 1'b0; tick(H);

      // R12 pause during read
      sel(); xfer(8'h03, r, o); xfer(8'h01, r, o); xfer(8'h00, r, o);
      xfer(8'h00, r, o);
      check(r == mm[10'h100], "R12 byte before pause", r, mm[10'h100]);
      spi_sck = 1'b0; tick(H);
      spi_hold_n = 1'b0; tick(2 * H);
      check(spi_so_oe == 1'b0, "R12 output off in pause", spi_so_oe, 0);
      for (int k = 0; k < 3; k++) begin
         spi_si = ~spi_si; spi_sck = 1'b1; tick(H); spi_sck = 1'b0; tick(H);
      end
      spi_hold_n = 1'b1; tick(2 * H);
      xfer(8'h00, r, o);
      check(o && r == mm[10'h101], "R12 resume same bit", r, mm[10'h101]);
      desel();

      // R13 repeated status
      cmd(8'h06);
      sel(); xfer(8'h05, r, o); xfer(8'h00, r, o); xfer(8'h00, r2, o); desel();
      check(r == 8'h02 && r2 == 8'h02, "R13 repeated status", {r, r2}, 16'h0202);
      cmd(8'h04);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule